// File: doc/BRIEF.md
# UART Prioritized Interrupt Identification Logic

This block gathers the interrupt conditions of a 16550-style serial port, masks each one with its enable, ranks the survivors by a fixed priority and holds the winner in an 8-bit read-only identification value. A processor reads that value to learn why the port raised its interrupt line. Software needs to know only the encoding of the low nibble, the autobaud bit and the FIFO-mode status field.

Beside the usual four-level encoded field, an autobaud-lock bit sits in the value. It rises and falls on its own and never moves the pending flag. Two sources depend on history. A receive timeout is withdrawn as soon as a new receive character arrives. A transmit request is dropped when the identification value is read while it shows that request. The block has no data stream, so all pins are plain level or strobe signals with no valid/ready handshake and no back-pressure. The value is registered and reflects the inputs of the previous clock edge.

Top module: `uart_irq_ident`

## Requirements
- R1: The encoded field shows only the highest-ranked active source. The ranking from highest to lowest is line-status error, receive data, receive timeout, transmit request, modem-status change. Receive data outranks the timeout inside their shared second level.
- R2: id_q[3:0] codes: line status 4'b0110, receive data 4'b0100, receive timeout 4'b1100, transmit request 4'b0010, modem status 4'b0000.
- R3: id_q[0] is an active-low pending flag. With no encoded source active, id_q[3:0] is 4'b0001.
- R4: A source takes part only while its enable is high. ie_rxd gates both receive data and receive timeout.
- R5: With fifo_en high, receive data follows rx_trig and the transmit request follows tx_half. With fifo_en low, they follow rx_hold and tx_done.
- R6: A receive timeout (rx_tmo) is reported only while fifo_en is high.
- R7: An rx_push pulse withdraws a pending timeout in the same cycle. The timeout stays withdrawn until rx_tmo goes low and then high again.
- R8: A read (rd_id high) while id_q[3:0] is 4'b0010 clears the transmit request. The request stays cleared until the selected transmit condition goes low and rises again. A read while another code is shown leaves the request pending.
- R9: id_q[4] is the autobaud-lock bit (abl_lock AND ie_abl). It never changes id_q[3:0]. irq is high when id_q[0] is 0 or id_q[4] is 1.
- R10: id_q[7:6] is 2'b11 in FIFO mode and 2'b00 otherwise. id_q[5] is always 0.
- R11: id_q updates on the clock edge after an input change. While rst_n is low, id_q is 8'h01 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | FIFO mode enable |
| ls_err | input | 1 | A receiver line-status error bit is set |
| rx_trig | input | 1 | Receive FIFO at trigger level |
| rx_hold | input | 1 | Receive holding register full |
| rx_tmo | input | 1 | Receive timeout condition from timer |
| rx_push | input | 1 | New receive character arrives (pulse) |
| tx_half | input | 1 | Transmit FIFO at least half empty |
| tx_done | input | 1 | Transmit holding register sent |
| ms_chg | input | 1 | A modem input changed |
| abl_lock | input | 1 | Autobaud lock reached |
| ie_line | input | 1 | Line-status interrupt enable |
| ie_rxd | input | 1 | Receive data and timeout enable |
| ie_txr | input | 1 | Transmit request enable |
| ie_mdm | input | 1 | Modem-status enable |
| ie_abl | input | 1 | Autobaud-lock enable |
| rd_id | input | 1 | Identification value is read this cycle |
| id_q | output | 8 | Identification value |
| irq | output | 1 | Combined interrupt line |

## Verification
Two things can fall in the same cycle: a read that would clear the transmit request, and an rx_push that withdraws a receive timeout. The bench first brings up a transmit request. It then raises a timeout, which hides the request behind the higher-ranked code, and pulses rd_id and rx_push together. The read saw the timeout code, not the transmit code, so the transmit request must survive. The next value must show 4'b0010, and only a later read may clear it. Before that, a sweep over every static input combination compares each value with a priority computation done in the bench.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC   = 5;
  localparam int CODE_W = 4;
  localparam int ID_W   = 8;

  localparam int IX_LINE = 0;
  localparam int IX_RXD  = 1;
  localparam int IX_TMO  = 2;
  localparam int IX_TXR  = 3;
  localparam int IX_MDM  = 4;

  localparam logic [CODE_W-1:0] CODE_NONE = 4'b0001;
  localparam logic [CODE_W-1:0] CODE_TXR  = 4'b0010;

  function automatic logic [CODE_W-1:0] src_code(input int idx);
    case (idx)
      IX_LINE: src_code = 4'b0110;
      IX_RXD:  src_code = 4'b0100;
      IX_TMO:  src_code = 4'b1100;
      IX_TXR:  src_code = CODE_TXR;
      default: src_code = 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_qual.sv
module uart_irq_qual
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fifo_en,
  input  logic            ls_err,
  input  logic            rx_trig,
  input  logic            rx_hold,
  input  logic            rx_tmo,
  input  logic            rx_push,
  input  logic            tx_half,
  input  logic            tx_done,
  input  logic            ms_chg,
  input  logic            ie_line,
  input  logic            ie_rxd,
  input  logic            ie_txr,
  input  logic            ie_mdm,
  input  logic            rd_id,
  input  logic            shows_txr,
  output logic [NSRC-1:0] act
);
  logic rx_src, tx_src;
  logic tmo_kill_q, tx_ack_q;
  logic tx_read_now;

  assign rx_src      = fifo_en ? rx_trig : rx_hold;
  assign tx_src      = fifo_en ? tx_half : tx_done;
  assign tx_read_now = rd_id & shows_txr;

  // timeout withdrawal: held until the timer condition drops
  always_ff @(posedge clk) begin
    if (!rst_n)       tmo_kill_q <= 1'b0;
    else if (!rx_tmo) tmo_kill_q <= 1'b0;
    else if (rx_push) tmo_kill_q <= 1'b1;
  end

  // transmit request acknowledged by a read of the identification value
  always_ff @(posedge clk) begin
    if (!rst_n)           tx_ack_q <= 1'b0;
    else if (!tx_src)     tx_ack_q <= 1'b0;
    else if (tx_read_now) tx_ack_q <= 1'b1;
  end

  always_comb begin
    act          = '0;
    act[IX_LINE] = ie_line & ls_err;
    act[IX_RXD]  = ie_rxd & rx_src;
    act[IX_TMO]  = ie_rxd & fifo_en & rx_tmo & ~rx_push & ~tmo_kill_q;
    act[IX_TXR]  = ie_txr & tx_src & ~tx_ack_q & ~tx_read_now;
    act[IX_MDM]  = ie_mdm & ms_chg;
  end

  assert_kill_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_kill_q && rx_tmo) |-> !act[IX_TMO]);
  assert_tmo_needs_fifo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> !act[IX_TMO]);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int N = NSRC
)(
  input  logic [N-1:0]      act,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-1:0] tbl [N];

  for (genvar g = 0; g < N; g++) begin : g_tbl
    assign tbl[g] = src_code(g);
  end

  // scan from lowest rank upward so the highest rank overwrites last
  always_comb begin
    code = CODE_NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (act[i]) code = tbl[i];
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fifo_en,
  input  logic            ls_err,
  input  logic            rx_trig,
  input  logic            rx_hold,
  input  logic            rx_tmo,
  input  logic            rx_push,
  input  logic            tx_half,
  input  logic            tx_done,
  input  logic            ms_chg,
  input  logic            abl_lock,
  input  logic            ie_line,
  input  logic            ie_rxd,
  input  logic            ie_txr,
  input  logic            ie_mdm,
  input  logic            ie_abl,
  input  logic            rd_id,
  output logic [ID_W-1:0] id_q,
  output logic            irq
);
  localparam logic [ID_W-1:0] ID_RST = {{(ID_W-CODE_W){1'b0}}, CODE_NONE};

  logic [NSRC-1:0]   act;
  logic [CODE_W-1:0] code;
  logic              shows_txr;

  assign shows_txr = (id_q[CODE_W-1:0] == CODE_TXR);

  uart_irq_qual u_qual (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ls_err(ls_err),
    .rx_trig(rx_trig), .rx_hold(rx_hold), .rx_tmo(rx_tmo), .rx_push(rx_push),
    .tx_half(tx_half), .tx_done(tx_done), .ms_chg(ms_chg),
    .ie_line(ie_line), .ie_rxd(ie_rxd), .ie_txr(ie_txr), .ie_mdm(ie_mdm),
    .rd_id(rd_id), .shows_txr(shows_txr), .act(act)
  );

  uart_irq_prio #(.N(NSRC)) u_prio (.act(act), .code(code));

  always_ff @(posedge clk) begin
    if (!rst_n) id_q <= ID_RST;
    else        id_q <= {fifo_en, fifo_en, 1'b0, abl_lock & ie_abl, code};
  end

  assign irq = ~id_q[0] | id_q[4];

  assert_idle_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    id_q[0] |-> (id_q[3:1] == 3'b000));
  assert_tmo_in_fifo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    id_q[3] |-> id_q[7]);
  assert_push_withdraws_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !id_q[3]);
  assert_read_clears_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_id && id_q[3:0] == 4'b0010) |=> (id_q[3:0] != 4'b0010));
  assert_line_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_err && ie_line) |=> (id_q[3:0] == 4'b0110));
  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (id_q[5] == 1'b0) && (id_q[7] == id_q[6]));
endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 0, ls_err = 0, rx_trig = 0, rx_hold = 0, rx_tmo = 0, rx_push = 0;
  logic tx_half = 0, tx_done = 0, ms_chg = 0, abl_lock = 0;
  logic ie_line = 0, ie_rxd = 0, ie_txr = 0, ie_mdm = 0, ie_abl = 0, rd_id = 0;
  logic [7:0] id_q;
  logic irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_irq_ident u_uart_irq_ident (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ls_err(ls_err),
    .rx_trig(rx_trig), .rx_hold(rx_hold), .rx_tmo(rx_tmo), .rx_push(rx_push),
    .tx_half(tx_half), .tx_done(tx_done), .ms_chg(ms_chg), .abl_lock(abl_lock),
    .ie_line(ie_line), .ie_rxd(ie_rxd), .ie_txr(ie_txr), .ie_mdm(ie_mdm),
    .ie_abl(ie_abl), .rd_id(rd_id), .id_q(id_q), .irq(irq)
  );

  task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got {irq,id}=%h expected %h", req, got, exp);
    end
  endtask

  // step one clock: inputs already set at negedge, sample at next negedge
  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [8:0] expect_of(input logic [13:0] v);
    logic fe, ls, rt, rh, tm, th, td, ms, ab, el, er, et, em, ea, rx, tx, ablb;
    logic [3:0] c;
    {fe, ls, rt, rh, tm, th, td, ms, ab, el, er, et, em, ea} = v;
    rx = fe ? rt : rh;
    tx = fe ? th : td;
    if (el & ls)            c = 4'b0110;
    else if (er & rx)       c = 4'b0100;
    else if (er & fe & tm)  c = 4'b1100;
    else if (et & tx)       c = 4'b0010;
    else if (em & ms)       c = 4'b0000;
    else                    c = 4'b0001;
    ablb = ab & ea;
    return {(c != 4'b0001) | ablb, fe, fe, 1'b0, ablb, c};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: got running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset", {irq, id_q}, 9'h001);
    rst_n = 1'b1;
    step();
    check("R11 after reset", {irq, id_q}, 9'h001);

    // static sweep: R1 R2 R3 R4 R5 R6 R9 R10
    for (int i = 0; i < 16384; i++) begin
      logic [13:0] v;
      v = 14'(i);
      {fifo_en, ls_err, rx_trig, rx_hold, rx_tmo, tx_half, tx_done, ms_chg,
       abl_lock, ie_line, ie_rxd, ie_txr, ie_mdm, ie_abl} = v;
      step();
      check("R1 R2 R3 R4 R5 R6 R9 R10 sweep", {irq, id_q}, expect_of(v));
    end

    {fifo_en, ls_err, rx_trig, rx_hold, rx_tmo, tx_half, tx_done, ms_chg,
     abl_lock, ie_line, ie_rxd, ie_txr, ie_mdm, ie_abl} = '0;
    step();
    check("R3 idle", {irq, id_q}, 9'h001);

    // R7 timeout withdrawal
    fifo_en = 1; ie_rxd = 1; rx_tmo = 1;
    step(); check("R7 timeout up", {irq, id_q}, 9'h1CC);
    rx_push = 1;
    step(); check("R7 push withdraws", {irq, id_q}, 9'h0C1);
    rx_push = 0;
    step(); check("R7 stays withdrawn", {irq, id_q}, 9'h0C1);
    step(); check("R7 stays withdrawn 2", {irq, id_q}, 9'h0C1);
    rx_tmo = 0;
    step(); check("R7 timer low", {irq, id_q}, 9'h0C1);
    rx_tmo = 1;
    step(); check("R7 re-arise", {irq, id_q}, 9'h1CC);
    rx_tmo = 0;
    step();

    // R8 transmit request clear on read
    ie_txr = 1; tx_half = 1;
    step(); check("R8 tx up", {irq, id_q}, 9'h1C2);
    rd_id = 1;
    step(); check("R8 read clears", {irq, id_q}, 9'h0C1);
    rd_id = 0;
    step(); check("R8 stays cleared", {irq, id_q}, 9'h0C1);
    tx_half = 0;
    step(); check("R8 condition low", {irq, id_q}, 9'h0C1);
    tx_half = 1;
    step(); check("R8 re-arise", {irq, id_q}, 9'h1C2);
    ie_line = 1; ls_err = 1;
    step(); check("R1 line over tx", {irq, id_q}, 9'h1C6);
    rd_id = 1;
    step(); check("R8 read of other code keeps tx", {irq, id_q}, 9'h1C6);
    rd_id = 0; ls_err = 0;
    step(); check("R8 tx survives", {irq, id_q}, 9'h1C2);

    // same-cycle: read while timeout shown, plus rx_push
    rx_tmo = 1;
    step(); check("R1 timeout over tx", {irq, id_q}, 9'h1CC);
    rd_id = 1; rx_push = 1;
    step(); check("R7 R8 concurrent", {irq, id_q}, 9'h1C2);
    rx_push = 0;
    step(); check("R8 later read clears", {irq, id_q}, 9'h0C1);
    rd_id = 0;

    // R9 autobaud independent of pending flag
    ie_abl = 1; abl_lock = 1;
    step(); check("R9 abl alone", {irq, id_q}, 9'h1D1);
    ie_mdm = 1; ms_chg = 1;
    step(); check("R9 abl with modem", {irq, id_q}, 9'h1D0);
    abl_lock = 0;
    step(); check("R9 abl drops", {irq, id_q}, 9'h1C0);

    // R6/R10 leaving FIFO mode
    fifo_en = 0; ms_chg = 0; rx_tmo = 1;
    step(); check("R6 R10 non-FIFO", {irq, id_q}, 9'h001);

    // R11 reset mid-run
    ms_chg = 1; abl_lock = 1;
    rst_n = 0;
    step(); check("R11 reset clears", {irq, id_q}, 9'h001);
    rst_n = 1;
    step(); check("R11 one-cycle update", {irq, id_q}, 9'h110);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule